// File: doc/BRIEF.md
# Multi-Bus Interrupt Status Aggregator

This block gathers interrupt conditions from a set of independent two-wire serial bus engines (fourteen by default) and folds them into one level-sensitive interrupt line. Every bus owns a 15-bit event status register and a 15-bit enable register. The event pulses from a bus engine build up in its status register. When that engine finishes a command it raises its evaluate strobe. The status is then pruned to the enabled events, and a non-empty result raises both that bus's bit in a read-only global summary word and the shared line.

Software reaches the registers through one simple register port. A window select picks either the global window or the window of one bus. A small offset picks a register inside that window. Reads are combinational, and a write takes effect at the next clock edge. Any write to a bus status register clears that bus's global bit and drops the shared line, even when status bits remain set or other buses are still flagged. The line comes back only when a later evaluation finds enabled events.

Top module: `irq_aggregator`

## Requirements
- R1: Each bit of `evt_pulse[b*15 +: 15]` that is high at a clock edge sets the same bit of bus b's status register, and the bit stays set without an evaluate. Bit meanings: 0 transmit acked, 1 transmit not acked, 2 receive done, 3 arbitration lost, 4 normal stop, 5 abnormal condition, 6 clock-line timeout, 7 address match as target, 13 bus recovery done, 14 data-line timeout.
- R2: When `evt_eval[b]` is high at an edge, bus b's status becomes (status with that cycle's clears and events applied) AND the enable value held before that edge. Disabled bits are erased, not just hidden.
- R3: In the bus window, offset 0 is the enable register. A write stores only `reg_wdata[14:0]`, and a read returns it zero-extended to 32 bits.
- R4: An evaluate with a non-zero result sets bit b of the global word and drives `irq` high from the next cycle. The global word is read at offset 0 of the global window (`reg_glb`=1), with bit b for bus b and zeros above.
- R5: Any write to bus b's status register, whatever its data, clears global bit b and drops `irq` from the next cycle, even with status bits still set. The only exception is an evaluate with a non-zero result in the same cycle, which wins.
- R6: In the bus window, offset 1 is the status register. A write clears every status bit whose position is set in `reg_wdata[14:0]`.
- R7: While `rst_n` is low at an edge, all enables, all status registers, the global word and `irq` are cleared.
- R8: `irq` holds its value until a status write drops it. An evaluate with a zero result leaves it unchanged, and a later evaluate with a non-zero result raises it again.
- R9: Writes to the global window have no effect on any register. Offsets other than 0 in the global window, and other than 0 and 1 in a bus window, read as zero.
- R10: When an event pulse and a status clear hit the same bit in one cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 210 | Event pulses, 15 per bus, bus b at bits b*15 +: 15 |
| evt_eval | input | 14 | Per-bus evaluate strobe, one per finished command |
| reg_we | input | 1 | Register write strobe |
| reg_glb | input | 1 | 1 selects the global window, 0 a bus window |
| reg_bus | input | 4 | Bus index for the bus window |
| reg_off | input | 2 | Register offset within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for the selected register |
| irq | output | 1 | Shared level interrupt |

## Verification
Assertions in the per-bus slot check every cycle that evaluated status stays inside the prior enable mask, that a set bit survives a same-cycle clear, that clears remove written bits, and that the global bit follows evaluate and status-write events. In the line logic they check the set, drop and hold rules of `irq`, and at the top they check that global-window writes leave the summary stable. Only the bench scenarios can show the cross-bus effects: a status write on one bus drops the line while another bus's global bit stays set, re-evaluation raises the line again, read-back of masked enable widths, and the full reset state seen at the port.

// File: rtl/aggr_pkg.sv
// Package: shared register-window constants for the interrupt aggregator.
// Assumes a two-bit offset field inside each register window.
package aggr_pkg;
    localparam int unsigned OFF_W      = 2;
    localparam int unsigned OFF_ENABLE = 0;  // bus window: enable register
    localparam int unsigned OFF_STATUS = 1;  // bus window: status register
    localparam int unsigned OFF_GLOBAL = 0;  // global window: summary word
endpackage

// File: rtl/bus_slot.sv
// Module: bus_slot
// Holds one bus's enable register, event status register and global summary
// bit. Events OR into status, software writes clear status bits, and an
// evaluate strobe prunes status to the enabled events and raises the summary
// bit when anything remains. Assumes the write strobes are already decoded
// for this bus and that wdata carries only the event-width field.
module bus_slot #(
    parameter int EV_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev,
    input  logic            eval,
    input  logic            en_we,
    input  logic            st_we,
    input  logic [EV_W-1:0] wdata,
    output logic [EV_W-1:0] en_q,
    output logic [EV_W-1:0] st_q,
    output logic            gbit,
    output logic            hit,
    output logic            clr
);
    logic [EV_W-1:0] st_clr;
    logic [EV_W-1:0] st_mid;
    logic [EV_W-1:0] st_masked;
    logic [EV_W-1:0] st_nxt;

    // Purpose: apply clear, then events (events win), then the evaluate mask.
    always_comb begin
        st_clr    = st_we ? wdata : '0;
        st_mid    = (st_q & ~st_clr) | ev;
        st_masked = st_mid & en_q;
        st_nxt    = eval ? st_masked : st_mid;
        hit       = eval && (st_masked != '0);
        clr       = st_we;
    end

    // Purpose: enable register, stores only the event-width field.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wdata;
    end

    // Purpose: event status register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_nxt;
    end

    // Purpose: global summary bit, set by a productive evaluate, cleared by any status write.
    always_ff @(posedge clk) begin
        if (!rst_n)     gbit <= 1'b0;
        else if (hit)   gbit <= 1'b1;
        else if (st_we) gbit <= 1'b0;
    end

    // R2: after an evaluate, no status bit lies outside the previous enable.
    p_eval_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> ((st_q & ~$past(en_q)) == '0));

    // R3: enable register takes the written field.
    p_en_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> (en_q == $past(wdata)));

    // R4: a non-empty evaluated status leaves the summary bit set.
    p_gbit_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> (st_q == '0 || gbit));

    // R5: a status write without an evaluate clears the summary bit.
    p_gbit_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !eval) |=> !gbit);

    // R6: written bits are cleared unless an event set them again.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !eval) |=> ((st_q & $past(wdata) & ~$past(ev)) == '0));

    // R10: an event bit is set after the edge even under a same-cycle clear.
    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval && ev != '0) |=> ((st_q & $past(ev)) == $past(ev)));
endmodule

// File: rtl/irq_line.sv
// Module: irq_line
// Drives the shared level interrupt. Set when any bus evaluates to a
// non-empty status, dropped by any bus status write, otherwise held.
// Assumes hit_any and clr_any are single-cycle qualified requests.
module irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_any,
    input  logic clr_any,
    output logic irq
);
    // Purpose: set-dominant interrupt flop.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (hit_any) irq <= 1'b1;
        else if (clr_any) irq <= 1'b0;
    end

    // R4: a productive evaluate raises the line.
    p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> irq);

    // R5: a status write drops the line when no evaluate sets it.
    p_irq_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_any && !hit_any) |=> !irq);

    // R8: with neither request, the line holds.
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_any && !hit_any) |=> $stable(irq));
endmodule

// File: rtl/reg_read_mux.sv
// Module: reg_read_mux
// Combinational read path. Selects the global summary word or one bus's
// enable or status register. Unmapped offsets and out-of-range bus indices
// read as zero. Assumes flattened per-bus register vectors.
module reg_read_mux
    import aggr_pkg::*;
#(
    parameter int N_BUS  = 14,
    parameter int EV_W   = 15,
    parameter int DATA_W = 32,
    parameter int BUS_AW = 4
) (
    input  logic [N_BUS*EV_W-1:0] en_flat,
    input  logic [N_BUS*EV_W-1:0] st_flat,
    input  logic [N_BUS-1:0]      gbits,
    input  logic                  sel_glb,
    input  logic [BUS_AW-1:0]     sel_bus,
    input  logic [OFF_W-1:0]      sel_off,
    output logic [DATA_W-1:0]     rdata
);
    // Purpose: decode window and offset into read data.
    always_comb begin
        rdata = '0;
        if (sel_glb) begin
            if (sel_off == OFF_W'(OFF_GLOBAL)) rdata = DATA_W'(gbits);
        end else begin
            for (int i = 0; i < N_BUS; i++) begin
                if (sel_bus == BUS_AW'(i)) begin
                    if (sel_off == OFF_W'(OFF_ENABLE))
                        rdata = DATA_W'(en_flat[i*EV_W +: EV_W]);
                    else if (sel_off == OFF_W'(OFF_STATUS))
                        rdata = DATA_W'(st_flat[i*EV_W +: EV_W]);
                end
            end
        end
    end
endmodule

// File: rtl/irq_aggregator.sv
// Module: irq_aggregator
// Top of the interrupt aggregator. Decodes register writes into per-bus
// strobes, instantiates one slot per bus, combines their requests into the
// shared line and presents the read path. Assumes one register access per
// cycle and EV_W <= DATA_W.
module irq_aggregator
    import aggr_pkg::*;
#(
    parameter  int N_BUS  = 14,
    parameter  int EV_W   = 15,
    parameter  int DATA_W = 32,
    localparam int BUS_AW = (N_BUS > 1) ? $clog2(N_BUS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_BUS*EV_W-1:0] evt_pulse,
    input  logic [N_BUS-1:0]      evt_eval,
    input  logic                  reg_we,
    input  logic                  reg_glb,
    input  logic [BUS_AW-1:0]     reg_bus,
    input  logic [OFF_W-1:0]      reg_off,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq
);
    logic [N_BUS*EV_W-1:0] en_flat;
    logic [N_BUS*EV_W-1:0] st_flat;
    logic [N_BUS-1:0]      glb_bits;
    logic [N_BUS-1:0]      hit_vec;
    logic [N_BUS-1:0]      clr_vec;
    logic [N_BUS-1:0]      en_we_vec;
    logic [N_BUS-1:0]      st_we_vec;
    logic                  unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:EV_W];

    // Purpose: per-bus write decode; the global window has no writable register.
    always_comb begin
        for (int i = 0; i < N_BUS; i++) begin
            en_we_vec[i] = reg_we && !reg_glb && (reg_bus == BUS_AW'(i))
                           && (reg_off == OFF_W'(OFF_ENABLE));
            st_we_vec[i] = reg_we && !reg_glb && (reg_bus == BUS_AW'(i))
                           && (reg_off == OFF_W'(OFF_STATUS));
        end
    end

    for (genvar b = 0; b < N_BUS; b++) begin : g_slot
        bus_slot #(.EV_W(EV_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (evt_pulse[b*EV_W +: EV_W]),
            .eval  (evt_eval[b]),
            .en_we (en_we_vec[b]),
            .st_we (st_we_vec[b]),
            .wdata (reg_wdata[EV_W-1:0]),
            .en_q  (en_flat[b*EV_W +: EV_W]),
            .st_q  (st_flat[b*EV_W +: EV_W]),
            .gbit  (glb_bits[b]),
            .hit   (hit_vec[b]),
            .clr   (clr_vec[b])
        );
    end

    irq_line u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_any (|hit_vec),
        .clr_any (|clr_vec),
        .irq     (irq)
    );

    reg_read_mux #(
        .N_BUS  (N_BUS),
        .EV_W   (EV_W),
        .DATA_W (DATA_W),
        .BUS_AW (BUS_AW)
    ) u_rd (
        .en_flat (en_flat),
        .st_flat (st_flat),
        .gbits   (glb_bits),
        .sel_glb (reg_glb),
        .sel_bus (reg_bus),
        .sel_off (reg_off),
        .rdata   (reg_rdata)
    );

    // R9: a global-window write with no evaluate leaves the summary word stable.
    p_glb_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_glb && evt_eval == '0) |=> $stable(glb_bits));

    // R5: at most one bus status register is written per cycle.
    p_one_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_we_vec));
endmodule

// File: tb/test_irq_aggregator.sv
// Scoreboard bench: driver tasks update a requirement model and push expected
// read results; a monitor pops them and compares against the ports.
module test_irq_aggregator;
    localparam int CLK_PERIOD = 10;
    localparam int N_BUS  = 14;
    localparam int EV_W   = 15;
    localparam int DATA_W = 32;
    localparam int BUS_AW = 4;
    localparam int OFF_W  = 2;

    typedef struct {
        logic [DATA_W-1:0] exp_d;
        logic              exp_irq;
        string             tag;
    } sb_item_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [N_BUS*EV_W-1:0] evt_pulse = '0;
    logic [N_BUS-1:0]      evt_eval = '0;
    logic                  reg_we = 1'b0;
    logic                  reg_glb = 1'b0;
    logic [BUS_AW-1:0]     reg_bus = '0;
    logic [OFF_W-1:0]      reg_off = '0;
    logic [DATA_W-1:0]     reg_wdata = '0;
    logic [DATA_W-1:0]     reg_rdata;
    logic                  irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    sb_item_t sb_q[$];

    logic [EV_W-1:0]  en_m [N_BUS];
    logic [EV_W-1:0]  st_m [N_BUS];
    logic [N_BUS-1:0] g_m;
    logic             irq_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator #(.N_BUS(N_BUS), .EV_W(EV_W), .DATA_W(DATA_W)) i_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_eval(evt_eval),
        .reg_we(reg_we), .reg_glb(reg_glb), .reg_bus(reg_bus), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic model_reset();
        for (int i = 0; i < N_BUS; i++) begin
            en_m[i] = '0;
            st_m[i] = '0;
        end
        g_m   = '0;
        irq_m = 1'b0;
    endtask

    // One clock of stimulus: events on bus eb, evaluate on bus vb, optional write.
    task automatic step(input int eb, input logic [EV_W-1:0] ebits,
                        input int vb, input logic veval,
                        input logic we, input logic glb, input int wb,
                        input int woff, input logic [DATA_W-1:0] wd);
        logic any_hit;
        logic any_clr;
        @(negedge clk);
        evt_pulse = '0;
        if (ebits != '0) evt_pulse[eb*EV_W +: EV_W] = ebits;
        evt_eval = '0;
        if (veval) evt_eval[vb] = 1'b1;
        reg_we = we; reg_glb = glb; reg_bus = BUS_AW'(wb);
        reg_off = OFF_W'(woff); reg_wdata = wd;
        any_hit = 1'b0;
        any_clr = 1'b0;
        for (int i = 0; i < N_BUS; i++) begin
            logic            st_wr;
            logic [EV_W-1:0] nx;
            logic            h;
            st_wr = we && !glb && (wb == i) && (woff == 1);
            nx = (st_m[i] & ~(st_wr ? wd[EV_W-1:0] : '0)) | ((i == eb) ? ebits : '0);
            h = 1'b0;
            if (veval && vb == i) begin
                nx = nx & en_m[i];
                h  = (nx != '0);
            end
            st_m[i] = nx;
            if (we && !glb && (wb == i) && (woff == 0)) en_m[i] = wd[EV_W-1:0];
            if (h) g_m[i] = 1'b1;
            else if (st_wr) g_m[i] = 1'b0;
            any_hit |= h;
            any_clr |= st_wr;
        end
        if (any_hit) irq_m = 1'b1;
        else if (any_clr) irq_m = 1'b0;
        @(negedge clk);
        evt_pulse = '0; evt_eval = '0; reg_we = 1'b0;
    endtask

    // Select a register, then push its expected value and line state.
    task automatic check(input logic glb, input int bus, input int off, input string tag);
        sb_item_t it;
        reg_glb = glb; reg_bus = BUS_AW'(bus); reg_off = OFF_W'(off);
        if (glb) it.exp_d = (off == 0) ? DATA_W'(g_m) : '0;
        else if (off == 0) it.exp_d = DATA_W'(en_m[bus]);
        else if (off == 1) it.exp_d = DATA_W'(st_m[bus]);
        else it.exp_d = '0;
        it.exp_irq = irq_m;
        it.tag = tag;
        #1;
        sb_q.push_back(it);
        #1;
    endtask

    // Monitor: pop and compare each expected item.
    initial begin
        forever begin
            sb_item_t it;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            n_cmp++;
            if (reg_rdata !== it.exp_d || irq !== it.exp_irq) begin
                n_bad++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         it.tag, reg_rdata, irq, it.exp_d, it.exp_irq);
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD*200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: rdata=%h irq=%b expected completion", reg_rdata, irq);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 0, 0, "R7 global word after reset");
        check(0, 3, 0, "R7 enable after reset");

        step(0, '0, 0, 0, 1, 0, 2, 0, 32'hFFFF_FFFF);
        check(0, 2, 0, "R3 enable keeps 15 bits");

        step(2, 15'h0005, 0, 0, 0, 0, 0, 0, '0);
        check(0, 2, 1, "R1 events held without evaluate");

        step(0, '0, 0, 0, 1, 0, 2, 0, 32'h0000_0004);
        step(0, '0, 2, 1, 0, 0, 0, 0, '0);
        check(0, 2, 1, "R2 evaluate erases disabled bits");
        check(1, 0, 0, "R4 global bit and line set");

        step(5, 15'h0003, 5, 1, 0, 0, 0, 0, '0);
        check(0, 5, 1, "R2 zero result with enable cleared");
        check(1, 0, 0, "R8 zero-result evaluate keeps line");

        step(0, '0, 0, 0, 1, 0, 2, 1, 32'h0000_0000);
        check(0, 2, 1, "R5 status still set after empty write");
        check(1, 0, 0, "R5 global bit and line dropped");

        step(0, '0, 0, 0, 1, 0, 2, 1, 32'hFFFF_0004);
        check(0, 2, 1, "R6 write-one clears status");

        step(0, '0, 0, 0, 1, 0, 13, 0, 32'h0000_6000);
        step(13, 15'h6000, 13, 1, 0, 0, 0, 0, '0);
        check(1, 0, 0, "R4 highest bus flags global bit");

        step(0, '0, 0, 0, 1, 0, 0, 1, 32'h0);
        check(1, 0, 0, "R5 other bus write drops line, bit stays");

        step(0, '0, 13, 1, 0, 0, 0, 0, '0);
        check(1, 0, 0, "R8 re-evaluate raises line again");

        step(0, '0, 0, 0, 1, 1, 0, 0, 32'hFFFF_FFFF);
        check(1, 0, 0, "R9 global write ignored");
        check(1, 0, 2, "R9 unmapped global offset reads zero");
        check(0, 13, 3, "R9 unmapped bus offset reads zero");

        step(4, 15'h0003, 0, 0, 0, 0, 0, 0, '0);
        step(4, 15'h0001, 0, 0, 1, 0, 4, 1, 32'h0000_0003);
        check(0, 4, 1, "R10 event beats same-cycle clear");

        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 0, 0, "R7 global word after mid-run reset");
        check(0, 13, 0, "R7 enable after mid-run reset");
        check(0, 4, 1, "R7 status after mid-run reset");

        #(CLK_PERIOD);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule